// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host on a two-wire serial bus read and write a bank of 8-bit configuration registers. Both bus lines are sampled on a faster system clock, start and stop conditions are found from the sampled levels, and the slave answers to a 7-bit device address whose lowest bit comes from a strap pin. Two slaves with opposite straps can therefore share one bus: write/read address bytes are 0x40/0x41 with the strap low and 0x42/0x43 with it high.

A write transfer carries the address byte, a starting register index and then any number of data bytes. Each data byte lands at the current index, and the index then steps by one. A read transfer sends register contents from the current index, which survives a repeated start, until the host declines a byte. The slave never drives SDA high. It only pulls it low through `sda_oe`, for acknowledge bits and for zero bits of read data. The bus has no back-pressure: the slave never stretches SCL, and the system clock must run at least eight times faster than SCL.

Top module: `i2c_cfg_slave`

## Requirements
- R1: Start is SDA falling while SCL is high; stop is SDA rising while SCL is high. Outside a transfer, and after reset, `sda_oe` is 0.
- R2: The first byte after a start is taken MSB first as seven address bits plus a direction bit (1 = read). When the address bits equal `{6'b010000, addr_strap}`, the slave pulls SDA low on the ninth clock. Otherwise it leaves SDA released and ignores the bus until the next start.
- R3: In a write, the second byte sets the register index. Every further acknowledged byte is stored at that index, and the index then increments.
- R4: A register index byte of 249 or above gets no acknowledge, and the slave goes idle.
- R5: A write data byte that arrives while the index is past 248 is not stored and gets no acknowledge, and the slave goes idle.
- R6: A read sends the register at the current index, MSB first. Each host acknowledge advances the index, but not beyond 248, so register 248 repeats.
- R7: A host no-acknowledge (SDA high on the ninth clock) ends the read. The slave then releases SDA until the next start.
- R8: The index set by a write is kept across a repeated start, so a following read begins there.
- R9: A start inside any byte abandons that byte without storing it, and the slave proceeds to receive an address.
- R10: A stop inside any byte abandons the transfer and makes the slave idle.
- R11: `sda_oe` changes only just after a sampled SCL falling edge.
- R12: All registers read as 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock level seen on the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| addr_strap | input | 1 | Selects the lowest bit of the 7-bit device address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except to form a start or a stop. They also assume that no start or stop is attempted while the slave holds SDA low, since the wired line could not rise then anyway. The bench host sets each data bit a quarter bus period after SCL falls and holds it until well after SCL falls again. It forms starts and stops only at bit boundaries, when the slave has released SDA. Each bus level stays stable for ten system clocks, which is longer than the synchronizer delay, so every edge is seen once and in order.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } phase_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } kind_t;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_in};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
  parameter int DEPTH = 249,
  parameter int BW    = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [BW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [BW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_clamped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_clamped = (rd_idx > LAST) ? LAST : rd_idx;
  assign rd_data    = mem[rd_clamped];

  // R5
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= LAST));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [5:0] DEV_ADDR_HI = 6'b010000,
  parameter int         NUM_REGS    = 249,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic addr_strap,
  output logic sda_oe
);
  import regport_pkg::*;

  localparam int BW    = 8;
  localparam int AW    = $clog2(NUM_REGS + 1);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [AW-1:0]    LAST_P = AW'(NUM_REGS - 1);
  localparam logic [CNT_W-1:0] BITS   = CNT_W'(BW);

  // line 0 = SCL, line 1 = SDA
  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(raw[g]),
      .level  (lvl[g]),
      .rise   (rise[g]),
      .fall   (fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  assign scl_lvl   = lvl[0];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign sda_lvl   = lvl[1];
  assign start_det = fall[1] & scl_lvl;
  assign stop_det  = rise[1] & scl_lvl;

  phase_t           phase;
  kind_t            kind;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    shreg;
  logic             rnw;
  logic             mack_ok;
  logic [AW-1:0]    ptr;

  logic             addr_hit, byte_ok, wr_en;
  logic [AW-1:0]    ptr_rd_next, rd_idx;
  logic [BW-1:0]    rd_data;

  assign addr_hit    = (shreg[BW-1:1] == {DEV_ADDR_HI, addr_strap});
  assign ptr_rd_next = (ptr >= LAST_P) ? ptr : ptr + 1'b1;
  assign rd_idx      = (phase == ST_MACK) ? ptr_rd_next : ptr;

  always_comb begin
    case (kind)
      K_ADDR:  byte_ok = addr_hit;
      K_SUB:   byte_ok = (AW'(shreg) <= LAST_P);
      default: byte_ok = (ptr <= LAST_P);
    endcase
  end

  assign wr_en = (phase == ST_RX) && (kind == K_DATA) && scl_fall &&
                 (cnt == BITS) && (ptr <= LAST_P);

  regport_bank #(.DEPTH(NUM_REGS), .BW(BW), .AW(AW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (ptr),
    .wr_data(shreg),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      kind    <= K_ADDR;
      cnt     <= '0;
      shreg   <= '0;
      rnw     <= 1'b0;
      mack_ok <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      phase  <= ST_RX;
      kind   <= K_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      phase  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (phase)
        ST_RX: begin
          if (scl_rise && cnt < BITS) begin
            shreg <= {shreg[BW-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == BITS) begin
            if (byte_ok) begin
              sda_oe <= 1'b1;
              phase  <= ST_ACK;
              case (kind)
                K_ADDR:  rnw <= shreg[0];
                K_SUB:   ptr <= AW'(shreg);
                default: ptr <= ptr + 1'b1;
              endcase
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (kind == K_ADDR && rnw) begin
              phase  <= ST_TX;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[BW-1];
            end else begin
              phase  <= ST_RX;
              sda_oe <= 1'b0;
              kind   <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == BITS) begin
              sda_oe <= 1'b0;
              phase  <= ST_MACK;
            end else begin
              shreg  <= {shreg[BW-2:0], 1'b0};
              sda_oe <= ~shreg[BW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_ok) begin
              ptr    <= ptr_rd_next;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[BW-1];
              cnt    <= '0;
              phase  <= ST_TX;
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE) |-> !sda_oe);

  // R11
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == ST_RX && kind == K_ADDR && cnt == '0));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase == ST_IDLE));

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_P + 1'b1);
endmodule

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int LAST       = 248;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_vec = 0;
  int n_bad = 0;
  int viol = 0;
  bit done = 0;
  logic oe_prev = 1'b0;
  int mem_m [249];
  int ptr_m = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_bus),
    .addr_strap(strap),
    .sda_oe    (sda_oe)
  );

  // R11: the slave's drive may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic rw);
    return {6'b010000, strap, rw};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b;  wait_q();
    scl = 1'b1; wait_q();
    seen = sda_bus; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic do_write(input int sub, input int dq[$], input string req);
    logic a;
    bit alive;
    bus_start();
    send_byte(addr_byte(1'b0), a); check(req, int'(a), 1);
    send_byte(sub[7:0], a);
    alive = (sub <= LAST);
    check(req, int'(a), int'(alive));
    if (alive) ptr_m = sub;
    foreach (dq[i]) begin
      send_byte(dq[i][7:0], a);
      if (alive && ptr_m <= LAST) begin
        mem_m[ptr_m] = dq[i];
        ptr_m++;
      end else begin
        alive = 0;
      end
      check(req, int'(a), int'(alive));
    end
    bus_stop();
  endtask

  // set index with a write header, repeated start, then read n bytes
  task automatic do_read(input int sub, input int n, input string req);
    logic a;
    logic [7:0] d;
    int idx;
    bus_start();
    send_byte(addr_byte(1'b0), a); check(req, int'(a), 1);
    send_byte(sub[7:0], a);        check(req, int'(a), 1);
    ptr_m = sub;
    bus_start();
    send_byte(addr_byte(1'b1), a); check(req, int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      idx = (ptr_m > LAST) ? LAST : ptr_m;
      check(req, int'(d), mem_m[idx]);
      if (k < n - 1 && ptr_m < LAST) ptr_m++;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int q[$];
    foreach (mem_m[i]) mem_m[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_q();

    // R1: released after reset
    check("R1", int'(sda_oe), 0);

    // R12: registers start at zero
    do_read(0, 3, "R12");
    do_read(LAST, 1, "R12");

    // R2: address matching with strap low, then high
    strap = 1'b0;
    bus_start();
    send_byte(8'h42, a); check("R2", int'(a), 0);
    send_byte(8'h00, a); check("R2", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'h43, a); check("R2", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'h40, a); check("R2", int'(a), 1);
    bus_stop();
    strap = 1'b1;
    bus_start();
    send_byte(8'h40, a); check("R2", int'(a), 0);
    bus_stop();
    q = '{8'h6C};
    do_write(3, q, "R2");
    do_read(3, 1, "R2");
    strap = 1'b0;

    // R3: autoincrementing write, read back
    q = '{8'h11, 8'hA5, 8'h3C};
    do_write(5, q, "R3");
    do_read(5, 3, "R3");

    // R4: out-of-range register index
    q = '{8'h77};
    do_write(249, q, "R4");
    do_write(255, q, "R4");
    do_read(5, 1, "R4");

    // R5: writing past the top
    q = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    do_write(247, q, "R5");
    do_read(246, 3, "R5");

    // R6: read saturates at the top register
    do_read(246, 5, "R6");

    // R7: host no-ack ends read; slave stays released
    bus_start();
    send_byte(addr_byte(1'b0), a); check("R7", int'(a), 1);
    send_byte(8'd5, a);            check("R7", int'(a), 1);
    bus_start();
    send_byte(addr_byte(1'b1), a); check("R7", int'(a), 1);
    recv_byte(1'b0, d);            check("R7", int'(d), mem_m[5]);
    ptr_m = 5;
    recv_byte(1'b0, d);            check("R7", int'(d), 8'hFF);
    bus_stop();

    // R8: index kept across repeated start (after a write advanced it)
    q = '{8'h99};
    mem_m[21] = 8'h5E;
    bus_start();
    send_byte(addr_byte(1'b0), a); check("R8", int'(a), 1);
    send_byte(8'd21, a);           check("R8", int'(a), 1);
    send_byte(8'h5E, a);           check("R8", int'(a), 1);
    bus_stop();
    bus_start();
    send_byte(addr_byte(1'b0), a); check("R8", int'(a), 1);
    send_byte(8'd20, a);           check("R8", int'(a), 1);
    send_byte(8'h99, a);           check("R8", int'(a), 1);
    mem_m[20] = 8'h99;
    bus_start();
    send_byte(addr_byte(1'b1), a); check("R8", int'(a), 1);
    recv_byte(1'b0, d);            check("R8", int'(d), mem_m[21]);
    bus_stop();

    // R9: start inside a data byte discards it
    bus_start();
    send_byte(addr_byte(1'b0), a); check("R9", int'(a), 1);
    send_byte(8'd31, a);           check("R9", int'(a), 1);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(addr_byte(1'b1), a); check("R9", int'(a), 1);
    recv_byte(1'b0, d);            check("R9", int'(d), 0);
    bus_stop();

    // R10: stop inside a data byte, then no response without a start
    bus_start();
    send_byte(addr_byte(1'b0), a); check("R10", int'(a), 1);
    send_byte(8'd40, a);           check("R10", int'(a), 1);
    send_bits(8'hE0, 3);
    bus_stop();
    sda_m = 1'b1; wait_q();
    scl = 1'b0;   wait_q();
    send_byte(addr_byte(1'b0), a); check("R10", int'(a), 0);
    scl = 1'b1; wait_q();
    bus_stop();
    do_read(40, 1, "R10");

    // R11: drive changes only while SCL low, over the whole run
    check("R11", viol, 0);
    check("R1", int'(sda_oe), 0);

    finish_run();
  end
endmodule